// File: doc/BRIEF.md
# Bridge Event Interrupt Register Unit

This unit gathers nine single-cycle event pulses from a video buffer-sharing bridge into sticky status bits. It turns the status bits that are not masked into one registered, level-sensitive interrupt line. Software reaches it over a simple 32-bit register bus. The bus has write and read strobes, a byte address and write data, and it returns read data combinationally in the same cycle as the read strobe.

Four words control the events, and every word uses the same bit-per-event order. The enable word decides which pulses may set status. The mask word hides status bits from the interrupt line. The clear word is write-one-to-clear and always reads as zero. The status word can also be written directly, which lets a handler write zero after acknowledging. A separate read-only word reports five live bridge conditions that arrive on an input port.

Top module: `evtIrqTop`

## Requirements
- R1: After reset the enable, mask and status words read zero and the interrupt line is low.
- R2: Event bit order, shared by the enable, mask, clear and status words at offsets 0x1C, 0x20, 0x24 and 0x28, is: bit 0 buffer overflow, 1 resync finished, 2 producer-connect timeout, 3 consumer-connect timeout, 4 consumer-handshake timeout, 5 producer connected, 6 producer disconnected, 7 consumer connected, 8 consumer disconnected. A pulse on `evtPulse[i]` with enable bit i at 1 sets status bit i at the next clock edge.
- R3: A pulse whose enable bit is 0 leaves the status bit unchanged.
- R4: A status bit stays set until it is cleared through the clear word or overwritten through the status word.
- R5: Writing the clear word clears each status bit whose write-data bit is 1. Bits written as 0 are left unchanged.
- R6: When an enabled pulse and a clear of the same bit fall in one cycle, the bit ends up set.
- R7: A write to the status word loads its bits 8:0 directly into status.
- R8: The interrupt line equals the OR of all status bits whose mask bit is 0, delayed by one register stage. It changes one cycle after status or mask changes.
- R9: Bits 31:9 of the enable, mask and status words read as zero, whatever value was written to them.
- R10: A read of the clear word returns zero, and a read of an unmapped offset returns zero.
- R11: A read of offset 0x80 returns `bridgeState` in bits 4:0: bit 0 producer connected, 1 consumer connected, 2 resync active, 3 luma overflow, 4 chroma overflow. The remaining bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtPulse | input | 9 | Event pulses, one per event bit |
| bridgeState | input | 5 | Live bridge conditions shown in the read-only word |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 8 | Register byte offset |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, valid while `busRdEn` is high |
| irqOut | output | 1 | Level interrupt line |

## Verification
The hardest case to reach is an enabled event pulse that arrives in the same clock cycle as a clear write to the same bit. The bench's write task can carry an event vector, so the pulse and the clear strobe are driven on the same cycle edge. The next status read then shows whether the set beat the clear. A second timing case comes from the interrupt stage sitting one register behind status and mask. Every interrupt check is therefore sampled one full cycle after the write or pulse that caused it, including a mask change that unmasks a bit which is already set.

// File: rtl/evtIrqPkg.sv
package evtIrqPkg;
  // Register byte offsets; software drivers decode these.
  localparam logic [7:0] OFS_ENABLE  = 8'h1C;
  localparam logic [7:0] OFS_MASK    = 8'h20;
  localparam logic [7:0] OFS_CLEAR   = 8'h24;
  localparam logic [7:0] OFS_STATUS  = 8'h28;
  localparam logic [7:0] OFS_GENERAL = 8'h80;

  // Strobes from the decoder to the register datapath.
  typedef struct packed {
    logic wrEnable;
    logic wrMask;
    logic wrClear;
    logic wrStatus;
    logic rdEnable;
    logic rdMask;
    logic rdStatus;
    logic rdGeneral;
  } regStrobeT;
endpackage

// File: rtl/evtIrqCtrl.sv
module evtIrqCtrl
  import evtIrqPkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobeT         strb
);
  localparam int unsigned OFS_W = 8;

  logic [OFS_W-1:0] ofs;

  generate
    if (ADDR_W >= OFS_W) begin : gWide
      assign ofs = busAddr[OFS_W-1:0];
      logic upperZero;
      if (ADDR_W > OFS_W) begin : gUpper
        assign upperZero = (busAddr[ADDR_W-1:OFS_W] == '0);
      end else begin : gNoUpper
        assign upperZero = 1'b1;
      end
      logic hit;
      assign hit = upperZero;
      always_comb begin
        strb = '0;
        if (hit) begin
          strb.wrEnable  = busWrEn && (ofs == OFS_ENABLE);
          strb.wrMask    = busWrEn && (ofs == OFS_MASK);
          strb.wrClear   = busWrEn && (ofs == OFS_CLEAR);
          strb.wrStatus  = busWrEn && (ofs == OFS_STATUS);
          strb.rdEnable  = busRdEn && (ofs == OFS_ENABLE);
          strb.rdMask    = busRdEn && (ofs == OFS_MASK);
          strb.rdStatus  = busRdEn && (ofs == OFS_STATUS);
          strb.rdGeneral = busRdEn && (ofs == OFS_GENERAL);
        end
      end
    end else begin : gNarrow
      assign ofs = OFS_W'(busAddr);
      always_comb begin
        strb = '0;
        strb.wrEnable  = busWrEn && (ofs == OFS_ENABLE);
        strb.wrMask    = busWrEn && (ofs == OFS_MASK);
        strb.wrClear   = busWrEn && (ofs == OFS_CLEAR);
        strb.wrStatus  = busWrEn && (ofs == OFS_STATUS);
        strb.rdEnable  = busRdEn && (ofs == OFS_ENABLE);
        strb.rdMask    = busRdEn && (ofs == OFS_MASK);
        strb.rdStatus  = busRdEn && (ofs == OFS_STATUS);
        strb.rdGeneral = busRdEn && (ofs == OFS_GENERAL);
      end
    end
  endgenerate

  // At most one write target and one read target per cycle.
  always_comb begin
    assert ($countones({strb.wrEnable, strb.wrMask, strb.wrClear, strb.wrStatus}) <= 1)
      else $error("AST_ONE_WRITE_TARGET"); // R2
  end
endmodule

// File: rtl/evtIrqDatapath.sv
module evtIrqDatapath
  import evtIrqPkg::*;
#(
  parameter int unsigned NUM_EVT = 9,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GEN_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobeT          strb,
  input  logic [DATA_W-1:0]  wData,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic [GEN_W-1:0]   bridgeState,
  output logic [DATA_W-1:0]  rData,
  output logic               irqOut
);
  logic [NUM_EVT-1:0] enableQ;
  logic [NUM_EVT-1:0] maskQ;
  logic [NUM_EVT-1:0] statusQ;
  logic [NUM_EVT-1:0] setVec;
  logic               irqQ;

  assign setVec = evtPulse & enableQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      maskQ   <= '0;
    end else begin
      if (strb.wrEnable) enableQ <= wData[NUM_EVT-1:0];
      if (strb.wrMask)   maskQ   <= wData[NUM_EVT-1:0];
    end
  end

  // One sticky flop per event; an enabled pulse outranks both write paths.
  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : gStatus
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        statusQ[i] <= 1'b0;
        else if (setVec[i])               statusQ[i] <= 1'b1;
        else if (strb.wrStatus)           statusQ[i] <= wData[i];
        else if (strb.wrClear && wData[i]) statusQ[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(statusQ & ~maskQ);
  end
  assign irqOut = irqQ;

  always_comb begin
    rData = '0;
    if (strb.rdEnable)  rData[NUM_EVT-1:0] = enableQ;
    if (strb.rdMask)    rData[NUM_EVT-1:0] = maskQ;
    if (strb.rdStatus)  rData[NUM_EVT-1:0] = statusQ;
    if (strb.rdGeneral) rData[GEN_W-1:0]   = bridgeState;
  end

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStatus |=> ((statusQ & ~$past(statusQ) & ~$past(enableQ)) == '0)); // R3
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrStatus && !strb.wrClear) |=> ((~statusQ & $past(statusQ)) == '0)); // R4
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((statusQ & $past(setVec)) == $past(setVec))); // R6
  AST_IRQ_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(statusQ & ~maskQ)))); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rData[DATA_W-1:NUM_EVT] == '0); // R9
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEnable == 1'b0 && strb.rdMask == 1'b0 && strb.rdStatus == 1'b0 &&
     strb.rdGeneral == 1'b0) |-> (rData == '0)); // R10
endmodule

// File: rtl/evtIrqTop.sv
module evtIrqTop
  import evtIrqPkg::*;
#(
  parameter int unsigned NUM_EVT = 9,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned GEN_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic [GEN_W-1:0]   bridgeState,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWData,
  output logic [DATA_W-1:0]  busRData,
  output logic               irqOut
);
  regStrobeT strb;

  evtIrqCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  evtIrqDatapath #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .GEN_W(GEN_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wData       (busWData),
    .evtPulse    (evtPulse),
    .bridgeState (bridgeState),
    .rData       (busRData),
    .irqOut      (irqOut)
  );
endmodule

// File: tb/tb_evtIrqTop.sv
`timescale 1ns/1ps
module tb_evtIrqTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  evtPulse = '0;
  logic [4:0]  bridgeState = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } itemT;
  itemT expQ[$];

  logic [8:0] mEn = '0, mMsk = '0, mSt = '0;

  always #2.5 clk = ~clk;

  evtIrqTop dut (.clk(clk), .rstN(rstN), .evtPulse(evtPulse), .bridgeState(bridgeState),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .busWData(busWData),
    .busRData(busRData), .irqOut(irqOut));

  // Monitor: compares every read against the queued expectation.
  always @(negedge clk) begin
    #1;
    if (busRdEn) begin
      itemT it;
      if (expQ.size() == 0) begin
        errors++; checks++;
        $display("FAIL scoreboard: read with no expectation, actual %h expected none", busRData);
      end else begin
        it = expQ.pop_front();
        checks++;
        if (busRData !== it.exp) begin
          errors++;
          $display("FAIL %s: read actual %h expected %h", it.tag, busRData, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [8:0] ev);
    logic [8:0] nxt;
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWData = d; evtPulse = ev;
    nxt = mSt;
    if (a == 8'h28) nxt = d[8:0];
    else if (a == 8'h24) nxt = mSt & ~d[8:0];
    mSt = nxt | (ev & mEn);
    if (a == 8'h1C) mEn = d[8:0];
    if (a == 8'h20) mMsk = d[8:0];
    @(negedge clk);
    busWrEn = 1'b0; evtPulse = '0;
  endtask

  task automatic pulse(input logic [8:0] ev);
    wr(8'h00, 32'h0, ev);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    itemT it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic chkIrq(input string tag);
    @(negedge clk); #1;
    checks++;
    if (irqOut !== |(mSt & ~mMsk)) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", tag, irqOut, |(mSt & ~mMsk));
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkIrq("R1");
    rd(8'h1C, 32'h0, "R1");
    rd(8'h20, 32'h0, "R1");
    rd(8'h28, 32'h0, "R1");
    // R3 pulses with enable cleared
    pulse(9'h1FF);
    rd(8'h28, 32'h0, "R3");
    chkIrq("R3");
    // R9 upper bits of enable drop
    wr(8'h1C, 32'hFFFF_FFFF, '0);
    rd(8'h1C, 32'h0000_01FF, "R9");
    // R2 bit 0 then bit 8
    pulse(9'h001);
    rd(8'h28, 32'h001, "R2");
    chkIrq("R8");
    pulse(9'h100);
    repeat (3) @(negedge clk);
    rd(8'h28, 32'h101, "R4");
    // R8 masking
    wr(8'h20, 32'hFFFF_F101, '0);
    chkIrq("R8");
    rd(8'h20, 32'h101, "R9");
    wr(8'h20, 32'h001, '0);
    chkIrq("R8");
    // R5 selective clear
    wr(8'h24, 32'h100, '0);
    rd(8'h28, 32'h001, "R5");
    chkIrq("R8");
    // R10 clear word and unmapped offsets read zero
    rd(8'h24, 32'h0, "R10");
    rd(8'h40, 32'h0, "R10");
    // R6 set beats clear in the same cycle
    wr(8'h24, 32'h001, 9'h001);
    rd(8'h28, 32'h001, "R6");
    wr(8'h24, 32'h1FF, 9'h008);
    rd(8'h28, 32'h008, "R6");
    // R7 direct status writes
    wr(8'h28, 32'hFFFF_F0F0, '0);
    rd(8'h28, 32'h0F0, "R7");
    chkIrq("R8");
    wr(8'h28, 32'h0, '0);
    rd(8'h28, 32'h0, "R7");
    chkIrq("R8");
    // R11 general word
    bridgeState = 5'h15;
    rd(8'h80, 32'h15, "R11");
    bridgeState = 5'h0A;
    rd(8'h80, 32'h0A, "R11");
    // R3 partial enable
    wr(8'h1C, 32'h0F0, '0);
    pulse(9'h1FF);
    rd(8'h28, 32'h0F0, "R3");
    chkIrq("R8");
    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: pending actual %0d expected 0", expQ.size());
    end
    finishRun();
  end
endmodule